// File: doc/BRIEF.md
# Shared Register Bus Selector

This block is the source side of the 16-bit common bus in a small accumulator machine. Six processor registers feed it, together with the read data from memory. The control logic raises one request line per cycle for the value it wants on the bus. The block turns those request lines into a 3-bit select code and uses that code to steer one source onto the bus. The select code is exported so it can be observed.

The address register and the program counter are 12 bits wide, and their upper four bus bits read as zero. The block also holds the 8-bit character output register, which is the one destination whose width differs from the bus. When its load enable is high at a clock edge, it captures the low byte of the bus.

The request-to-bus path has no register in it. A request placed early in a cycle is seen on the bus in that same cycle, ready for whichever destination loads at the next edge. If more than one line is raised, the highest-numbered line wins. A simulation checker reports the conflict.

Top module: `shbus_selector`

## Requirements
- R1: Request line k (bit k-1 of `src_req`) gives select code k on `bus_sel`: line 1 address register (001), line 2 program counter (010), line 3 data register (011), line 4 accumulator (100), line 5 instruction register (101), line 6 temporary register (110), line 7 memory read data (111).
- R2: With no request line high, `bus_sel` is 000 and `bus_data` is all zeros.
- R3: With one request line high, `bus_data` equals the value of the source that line names.
- R4: When the address register or the program counter is on the bus, bits 15 to 12 of `bus_data` are zero and bits 11 to 0 carry the register.
- R5: With several request lines high, the highest-numbered line sets `bus_sel` and `bus_data`, and every higher line is low.
- R6: `bus_sel` and `bus_data` follow `src_req` and the source values with no clock edge in between.
- R7: At a rising clock edge with `out_load` high, `out_char` takes bits 7 to 0 of `bus_data`. With `out_load` low, `out_char` keeps its value.
- R8: A synchronous active-high `rst` sampled at a rising edge clears `out_char` to zero, and this overrides `out_load`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output character register |
| rst | input | 1 | Synchronous active-high reset |
| src_req | input | 7 | One request per source; bit 0 is line 1 |
| addr_q | input | 12 | Address register contents |
| pc_q | input | 12 | Program counter contents |
| data_q | input | 16 | Data register contents |
| acc_q | input | 16 | Accumulator contents |
| instr_q | input | 16 | Instruction register contents |
| temp_q | input | 16 | Temporary register contents |
| mem_rdata | input | 16 | Memory read data |
| out_load | input | 1 | Load enable of the output character register |
| bus_sel | output | 3 | Encoded select code (000 means no source) |
| bus_data | output | 16 | Common bus value |
| out_char | output | 8 | Output character register |

## Verification
Conflict resolution and the output-register capture can happen in the same cycle. This occurs when two or more request lines are high while `out_load` is also high. The bench sets up this case with the accumulator and memory read data requested together, and also with a 12-bit register requested alongside a higher source. It then checks that the captured byte is the low byte of the winning source only, never the loser's and never an OR of the two. It also checks that the select code names the winner in the cycle before the edge.

// File: rtl/shbus_pkg.sv
package shbus_pkg;
  localparam int unsigned SHB_DATA_W = 16;
  localparam int unsigned SHB_ADDR_W = 12;
  localparam int unsigned SHB_CHAR_W = 8;
  localparam int unsigned SHB_NSRC   = 7;
  localparam int unsigned SHB_SEL_W  = $clog2(SHB_NSRC + 1);

  // Select code values; position in the request vector is code minus one.
  typedef enum logic [SHB_SEL_W-1:0] {
    SEL_NONE  = 3'd0,
    SEL_ADDR  = 3'd1,
    SEL_PC    = 3'd2,
    SEL_DATA  = 3'd3,
    SEL_ACC   = 3'd4,
    SEL_INSTR = 3'd5,
    SEL_TEMP  = 3'd6,
    SEL_MEM   = 3'd7
  } shb_sel_e;
endpackage

// File: rtl/shbus_req_encoder.sv
module shbus_req_encoder #(
  parameter int unsigned NSRC  = shbus_pkg::SHB_NSRC,
  parameter int unsigned SEL_W = $clog2(NSRC + 1)
) (
  input  logic [NSRC-1:0]  req,
  output logic [SEL_W-1:0] sel
);
  // Scan upward so the last (highest) active line overrides lower ones.
  always_comb begin
    sel = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (req[i]) sel = SEL_W'(i + 1);
    end
  end
endmodule

// File: rtl/shbus_src_mux.sv
module shbus_src_mux #(
  parameter int unsigned NSRC   = shbus_pkg::SHB_NSRC,
  parameter int unsigned DATA_W = shbus_pkg::SHB_DATA_W,
  parameter int unsigned SEL_W  = $clog2(NSRC + 1)
) (
  input  logic [NSRC-1:0][DATA_W-1:0] srcs,
  input  logic [SEL_W-1:0]            sel,
  output logic [DATA_W-1:0]           bus
);
  // AND-OR mux: each source gated by its own code match; code 0 matches none.
  logic [NSRC-1:0][DATA_W-1:0] gated;

  for (genvar g = 0; g < NSRC; g++) begin : g_gate
    assign gated[g] = (sel == SEL_W'(g + 1)) ? srcs[g] : '0;
  end

  always_comb begin
    bus = '0;
    for (int i = 0; i < NSRC; i++) bus = bus | gated[i];
  end
endmodule

// File: rtl/shbus_zext.sv
module shbus_zext #(
  parameter int unsigned IN_W  = shbus_pkg::SHB_ADDR_W,
  parameter int unsigned OUT_W = shbus_pkg::SHB_DATA_W
) (
  input  logic [IN_W-1:0]  din,
  output logic [OUT_W-1:0] dout
);
  localparam int unsigned PAD_W = OUT_W - IN_W;

  if (PAD_W == 0) begin : g_same
    assign dout = din;
  end else begin : g_pad
    assign dout = {{PAD_W{1'b0}}, din};
  end
endmodule

// File: rtl/shbus_char_reg.sv
module shbus_char_reg #(
  parameter int unsigned DATA_W = shbus_pkg::SHB_DATA_W,
  parameter int unsigned CHAR_W = shbus_pkg::SHB_CHAR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] bus,
  output logic [CHAR_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= bus[CHAR_W-1:0];
  end
endmodule

// File: rtl/shbus_selector.sv
module shbus_selector #(
  parameter int unsigned DATA_W = shbus_pkg::SHB_DATA_W,
  parameter int unsigned ADDR_W = shbus_pkg::SHB_ADDR_W,
  parameter int unsigned CHAR_W = shbus_pkg::SHB_CHAR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [6:0]        src_req,
  input  logic [ADDR_W-1:0] addr_q,
  input  logic [ADDR_W-1:0] pc_q,
  input  logic [DATA_W-1:0] data_q,
  input  logic [DATA_W-1:0] acc_q,
  input  logic [DATA_W-1:0] instr_q,
  input  logic [DATA_W-1:0] temp_q,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              out_load,
  output logic [2:0]        bus_sel,
  output logic [DATA_W-1:0] bus_data,
  output logic [CHAR_W-1:0] out_char
);
  localparam int unsigned NSRC  = shbus_pkg::SHB_NSRC;
  localparam int unsigned SEL_W = $clog2(NSRC + 1);

  logic [NSRC-1:0][DATA_W-1:0] srcs;
  logic [DATA_W-1:0]           addr_wide;
  logic [DATA_W-1:0]           pc_wide;

  shbus_zext #(.IN_W(ADDR_W), .OUT_W(DATA_W)) i_zext_addr (.din(addr_q), .dout(addr_wide));
  shbus_zext #(.IN_W(ADDR_W), .OUT_W(DATA_W)) i_zext_pc   (.din(pc_q),   .dout(pc_wide));

  // Order fixes the code map: index i carries select code i+1.
  assign srcs[shbus_pkg::SEL_ADDR  - 1] = addr_wide;
  assign srcs[shbus_pkg::SEL_PC    - 1] = pc_wide;
  assign srcs[shbus_pkg::SEL_DATA  - 1] = data_q;
  assign srcs[shbus_pkg::SEL_ACC   - 1] = acc_q;
  assign srcs[shbus_pkg::SEL_INSTR - 1] = instr_q;
  assign srcs[shbus_pkg::SEL_TEMP  - 1] = temp_q;
  assign srcs[shbus_pkg::SEL_MEM   - 1] = mem_rdata;

  shbus_req_encoder #(.NSRC(NSRC), .SEL_W(SEL_W)) i_enc (
    .req (src_req),
    .sel (bus_sel)
  );

  shbus_src_mux #(.NSRC(NSRC), .DATA_W(DATA_W), .SEL_W(SEL_W)) i_mux (
    .srcs (srcs),
    .sel  (bus_sel),
    .bus  (bus_data)
  );

  shbus_char_reg #(.DATA_W(DATA_W), .CHAR_W(CHAR_W)) i_char (
    .clk  (clk),
    .rst  (rst),
    .load (out_load),
    .bus  (bus_data),
    .q    (out_char)
  );
endmodule

// File: rtl/shbus_selector_chk.sv
module shbus_selector_chk #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned CHAR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [6:0]        src_req,
  input logic              out_load,
  input logic [2:0]        bus_sel,
  input logic [DATA_W-1:0] bus_data,
  input logic [CHAR_W-1:0] out_char
);
  // R2: idle request gives code zero and a zero bus
  assert_idle_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (src_req == '0) |-> (bus_sel == '0 && bus_data == '0));

  // R1: any active request yields a nonzero code naming an active line
  assert_code_names_line_R1: assert property (@(posedge clk) disable iff (rst)
    (src_req != '0) |-> (bus_sel != '0 && src_req[bus_sel - 3'd1]));

  // R5: no line above the selected one is active
  assert_highest_wins_R5: assert property (@(posedge clk) disable iff (rst)
    ((src_req >> bus_sel) == '0));

  // R4: narrow registers leave the upper bus bits at zero
  assert_zero_fill_R4: assert property (@(posedge clk) disable iff (rst)
    (bus_sel == 3'd1 || bus_sel == 3'd2) |-> (bus_data[DATA_W-1:ADDR_W] == '0));

  // R7: load captures the low byte, no load holds
  assert_char_load_R7: assert property (@(posedge clk) disable iff (rst)
    out_load |=> (out_char == $past(bus_data[CHAR_W-1:0])));

  assert_char_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !out_load |=> $stable(out_char));

  // R5: conflict flag in simulation
  always @(posedge clk) begin
    if (!rst && $countones(src_req) > 1)
      $display("note: request conflict %b, code %0d chosen", src_req, bus_sel);
  end
endmodule

bind shbus_selector shbus_selector_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CHAR_W(CHAR_W)
) i_chk (
  .clk      (clk),
  .rst      (rst),
  .src_req  (src_req),
  .out_load (out_load),
  .bus_sel  (bus_sel),
  .bus_data (bus_data),
  .out_char (out_char)
);

// File: tb/test_shbus_selector.sv
`timescale 1ns/1ps
module test_shbus_selector;
  logic        clk = 1'b0;
  logic        rst;
  logic [6:0]  src_req;
  logic [11:0] addr_q, pc_q;
  logic [15:0] data_q, acc_q, instr_q, temp_q, mem_rdata;
  logic        out_load;
  logic [2:0]  bus_sel;
  logic [15:0] bus_data;
  logic [7:0]  out_char;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  shbus_selector i_shbus_selector (
    .clk(clk), .rst(rst), .src_req(src_req),
    .addr_q(addr_q), .pc_q(pc_q), .data_q(data_q), .acc_q(acc_q),
    .instr_q(instr_q), .temp_q(temp_q), .mem_rdata(mem_rdata),
    .out_load(out_load), .bus_sel(bus_sel), .bus_data(bus_data),
    .out_char(out_char)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Expected bus value for line k (1..7), from the requirement map.
  function automatic logic [15:0] src_val(input int k);
    case (k)
      1: return {4'h0, addr_q};
      2: return {4'h0, pc_q};
      3: return data_q;
      4: return acc_q;
      5: return instr_q;
      6: return temp_q;
      7: return mem_rdata;
      default: return 16'h0000;
    endcase
  endfunction

  task automatic set_vals();
    addr_q = 12'hABC; pc_q = 12'h123; data_q = 16'hD00D; acc_q = 16'h5A3C;
    instr_q = 16'h7E81; temp_q = 16'h0F96; mem_rdata = 16'hC3B4;
  endtask

  task automatic t_reset();
    @(negedge clk); rst = 1'b1; out_load = 1'b1; src_req = 7'b1000000;
    @(posedge clk); #1;
    check("R8 reset clears out_char over load", {8'h00, out_char}, 16'h0000);
    @(negedge clk); rst = 1'b0; out_load = 1'b0; src_req = '0;
  endtask

  task automatic t_idle();
    @(negedge clk); src_req = '0; #1;
    check("R2 idle code", {13'd0, bus_sel}, 16'd0);
    check("R2 idle bus", bus_data, 16'h0000);
  endtask

  task automatic t_each_source();
    for (int k = 1; k <= 7; k++) begin
      @(negedge clk); src_req = 7'(1 << (k - 1)); #1;
      check("R1 code map", {13'd0, bus_sel}, 16'(k));
      check("R3 bus value", bus_data, src_val(k));
      if (k <= 2) check("R4 upper bits zero", {12'd0, bus_data[15:12]}, 16'd0);
    end
    // all-ones narrow register still zero-filled
    @(negedge clk); pc_q = 12'hFFF; src_req = 7'b0000010; #1;
    check("R4 pc FFF zero-filled", bus_data, 16'h0FFF);
    set_vals();
  endtask

  task automatic t_priority();
    @(negedge clk); src_req = 7'b0001001; #1;
    check("R5 lines 1+4 code", {13'd0, bus_sel}, 16'd4);
    check("R5 lines 1+4 bus", bus_data, acc_q);
    @(negedge clk); src_req = 7'b1111111; #1;
    check("R5 all lines code", {13'd0, bus_sel}, 16'd7);
    check("R5 all lines bus", bus_data, mem_rdata);
    @(negedge clk); src_req = 7'b0100110; #1;
    check("R5 lines 2+3+6 bus", bus_data, temp_q);
  endtask

  task automatic t_comb();
    // changes between edges reach outputs without a clock edge
    @(posedge clk); #1; src_req = 7'b0000100; #1;
    check("R6 bus follows request", bus_data, data_q);
    data_q = 16'h1357; #1;
    check("R6 bus follows source", bus_data, 16'h1357);
    src_req = 7'b0010000; #1;
    check("R6 code follows request", {13'd0, bus_sel}, 16'd5);
    set_vals();
  endtask

  task automatic t_out_load();
    @(negedge clk); src_req = 7'b0000100; out_load = 1'b1;
    @(posedge clk); #1;
    check("R7 load low byte of data reg", {8'h00, out_char}, 16'h000D);
    @(negedge clk); src_req = 7'b0001000; out_load = 1'b0;
    @(posedge clk); #1;
    check("R7 hold without load", {8'h00, out_char}, 16'h000D);
    @(negedge clk); src_req = '0; out_load = 1'b1;
    @(posedge clk); #1;
    check("R7 load from idle bus", {8'h00, out_char}, 16'h0000);
    @(negedge clk); out_load = 1'b0;
  endtask

  task automatic t_conflict_load();
    @(negedge clk); src_req = 7'b1001000; out_load = 1'b1; #1;
    check("R5 conflict code before edge", {13'd0, bus_sel}, 16'd7);
    @(posedge clk); #1;
    check("R7 conflict captures winner byte", {8'h00, out_char}, {8'h00, mem_rdata[7:0]});
    @(negedge clk); src_req = 7'b0100001; #1;
    @(posedge clk); #1;
    check("R7 conflict narrow loser", {8'h00, out_char}, {8'h00, temp_q[7:0]});
    @(negedge clk); out_load = 1'b0; src_req = '0;
  endtask

  initial begin
    rst = 1'b1; out_load = 1'b0; src_req = '0; set_vals();
    repeat (2) @(posedge clk);
    t_reset();
    t_idle();
    t_each_source();
    t_priority();
    t_comb();
    t_out_load();
    t_conflict_load();
    done = 1'b1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (5000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule